// File: doc/BRIEF.md
# Store Address Watch Unit

This block lets a core arm a watch on one aligned block of memory and find out later whether any store has written into it. A wait-for-event path uses the result to decide whether the core can sleep. An arm request carries three values: an effective address, an extension word and a hint word. The unit checks the request and returns a status code. On success it latches the line-aligned base of the address.

A snoop port presents every store in the system with its address and memory type. Only write-back stores that land in the armed line set the fired flag. A wait request gets one of two answers: "wake now", or "sleep". In the sleep case a one-cycle wake pulse follows on the first matching store. Every completed wait disarms the watch. The next wait therefore needs a fresh arm.

A global disable input makes the feature look absent and turns each arm request into an illegal-operation error. The size of the watched line is a parameter, and it is also driven onto an output so that software can read it.

Top module: `store_watch_unit`

## Requirements
- R1: After a synchronous reset, `watch_armed`, `watch_fired`, `arm_rsp_valid`, `wait_rsp_valid` and `wake_pulse` are all 0. The latched base is 0, and a write-back store to address 0 does not set `watch_fired` while the unit is unarmed.
- R2: Arm success condition: `feature_off`=0 and `arm_ext`=0 in an arm request.
  - One cycle after such a request, `arm_rsp_valid`=1 and `arm_rsp_code`=2'b00 (success).
  - `watch_armed`=1 from then on.
  - The base becomes `arm_addr` with its low log2(LINE_BYTES) bits cleared.
- R3: Fire on a matching store. While armed, take a store with `st_valid`=1, `st_mtype`=2'b11 (write-back), and `st_addr` in the armed line, i.e. (`st_addr` & ~(LINE_BYTES-1)) equals the base. Such a store sets `watch_fired` one cycle later. A store to any other line, including the two neighbouring lines, leaves it unchanged.
- R4: Stores whose `st_mtype` is 2'b00, 2'b01 or 2'b10 (not write-back) never change `watch_fired`, even when they hit the armed line.
- R5: Bad extension word.
  - An arm request with `feature_off`=0 and any nonzero bit in `arm_ext` answers `arm_rsp_code`=2'b01 (protection fault).
  - It leaves `watch_armed`, `watch_fired` and the base unchanged.
- R6: The value of `arm_hint` has no effect. An arm request with an all-ones hint behaves exactly like one with a zero hint.
- R7: Global disable (`feature_off`=1).
  - `feature_present` reads 0.
  - Every arm request answers `arm_rsp_code`=2'b10 (illegal operation) and leaves the watch unchanged.
  - With `feature_off`=0, `feature_present` reads 1.
- R8: `line_bytes` always equals the LINE_BYTES parameter (default 64).
- R9: Arm and store in the same cycle.
  - A successful arm clears `watch_fired` for the newly armed line.
  - A matching write-back store in the same cycle as the arm sets `watch_fired`. The store is compared against the newly requested line, not the old base.
- R10: "Wake now" wait. A wait request finds one of these: the unit unarmed, `watch_fired`=1, or a matching write-back store in the same cycle. One cycle later it answers `wait_rsp_valid`=1 and `wait_rsp_now`=1, and `watch_armed` becomes 0.
- R11: Sleeping wait and wake.
  - A wait request on an armed, unfired unit answers `wait_rsp_now`=0 and leaves `watch_armed`=1.
  - The first later matching write-back store raises `wake_pulse` for exactly one cycle, one cycle after the store. In that cycle `watch_armed`=0 and `watch_fired`=1.
  - Stores that do not match raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| feature_off | input | 1 | Global disable of the watch feature |
| feature_present | output | 1 | 1 when the feature is enabled |
| line_bytes | output | 16 | Size in bytes of the watched line |
| arm_req | input | 1 | Arm request strobe |
| arm_addr | input | ADDR_W | Effective address to watch |
| arm_ext | input | EXT_W | Extension word, must be zero |
| arm_hint | input | HINT_W | Hint word, discarded |
| arm_rsp_valid | output | 1 | Arm response strobe, one cycle after the request |
| arm_rsp_code | output | 2 | 00 success, 01 protection fault, 10 illegal operation |
| st_valid | input | 1 | Snooped store valid |
| st_addr | input | ADDR_W | Snooped store address |
| st_mtype | input | 2 | Store memory type, 2'b11 = write-back |
| wait_req | input | 1 | Wait request strobe |
| wait_rsp_valid | output | 1 | Wait response strobe, one cycle after the request |
| wait_rsp_now | output | 1 | 1 = wake now, 0 = sleep |
| wake_pulse | output | 1 | One-cycle wake for a sleeping waiter |
| watch_armed | output | 1 | Watch is armed |
| watch_fired | output | 1 | A matching write-back store has been seen |

## Verification
The store match is driven with several kinds of store address:
- addresses at both ends of the armed line and at its middle, which show that the low offset bits are masked;
- the last byte below the line and the first byte above it, which show that the comparison stops at the line boundary;
- the old base after a refused arm, which tells "watch unchanged" apart from "watch moved".

Memory type is swept over all four codes on a hitting address, to separate the write-back qualification from the address match. Arm and wait requests are paired with a same-cycle store, which exposes any ordering error between clearing and setting the fired flag.

// File: rtl/swu_pkg.sv
// Shared types for the store address watch unit.
// Assumes: two-bit memory type and two-bit arm status codes.
package swu_pkg;
    typedef enum logic [1:0] {
        ARM_OK  = 2'b00,
        ARM_GPF = 2'b01,
        ARM_ILL = 2'b10
    } arm_code_t;

    localparam logic [1:0] MT_WRITE_BACK = 2'b11;
endpackage

// File: rtl/swu_arm_check.sv
// Validates an arm request and produces its status code.
// Assumes: the hint word never reaches this block; the disable is checked before the extension word.
module swu_arm_check
    import swu_pkg::*;
#(
    parameter int EXT_W = 32
) (
    input  logic             arm_req,
    input  logic             feature_off,
    input  logic [EXT_W-1:0] arm_ext,
    output logic             arm_ok,
    output arm_code_t        arm_code
);
    // Pick the status: illegal when disabled, fault on a nonzero extension word, otherwise success.
    always_comb begin
        if (feature_off) begin
            arm_code = ARM_ILL;
        end else if (arm_ext != '0) begin
            arm_code = ARM_GPF;
        end else begin
            arm_code = ARM_OK;
        end
        arm_ok = arm_req && (arm_code == ARM_OK);
    end
endmodule

// File: rtl/swu_line_match.sv
// Compares two addresses at line granularity.
// Assumes: LINE_BYTES is a power of two no larger than the address space.
module swu_line_match #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_line
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] HI_MASK = {ADDR_W{1'b1}} << OFS_W;

    // Equal when every bit above the line offset agrees.
    always_comb begin
        same_line = ((addr_a ^ addr_b) & HI_MASK) == '0;
    end
endmodule

// File: rtl/swu_watch_state.sv
// Holds the armed bit, fired flag, latched base and sleeping waiter, and registers all responses.
// Assumes: st_hit is already qualified by valid, write-back type, armed-or-arming and line match.
module swu_watch_state
    import swu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_req,
    input  logic              arm_ok,
    input  arm_code_t         arm_code,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              st_hit,
    input  logic              wait_req,
    output logic [ADDR_W-1:0] base,
    output logic              armed,
    output logic              fired,
    output logic              arm_rsp_valid,
    output arm_code_t         arm_rsp_code,
    output logic              wait_rsp_valid,
    output logic              wait_rsp_now,
    output logic              wake_pulse
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] HI_MASK = {ADDR_W{1'b1}} << OFS_W;

    logic sleeping;
    logic wait_now;
    logic wake_hit;

    // Decide whether a wait completes at once and whether a sleeper is woken.
    always_comb begin
        wait_now = !armed || fired || st_hit;
        wake_hit = sleeping && st_hit;
    end

    // Watch state: an arm sets armed and resets fired; a store hit wins over that reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            fired <= 1'b0;
            base  <= '0;
        end else begin
            if (arm_ok) begin
                armed <= 1'b1;
                base  <= arm_addr & HI_MASK;
                fired <= st_hit;
            end else begin
                fired <= fired || st_hit;
                if ((wait_req && wait_now) || wake_hit) begin
                    armed <= 1'b0;
                end
            end
        end
    end

    // Sleeping waiter: set by a wait that must sleep, cleared by its wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleeping <= 1'b0;
        end else if (wait_req && !wait_now) begin
            sleeping <= 1'b1;
        end else if (wake_hit) begin
            sleeping <= 1'b0;
        end
    end

    // Registered responses and wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_rsp_valid  <= 1'b0;
            arm_rsp_code   <= ARM_OK;
            wait_rsp_valid <= 1'b0;
            wait_rsp_now   <= 1'b0;
            wake_pulse     <= 1'b0;
        end else begin
            arm_rsp_valid  <= arm_req;
            arm_rsp_code   <= arm_req ? arm_code : ARM_OK;
            wait_rsp_valid <= wait_req;
            wait_rsp_now   <= wait_req && wait_now;
            wake_pulse     <= wake_hit;
        end
    end
endmodule

// File: rtl/store_watch_unit.sv
// Top of the store address watch unit: validates arm requests, matches snooped stores
// against the armed line and answers wait requests.
// Assumes: callers do not issue an arm and a wait in the same cycle; if they do, the arm wins.
module store_watch_unit
    import swu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int EXT_W      = 32,
    parameter int HINT_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feature_off,
    output logic              feature_present,
    output logic [15:0]       line_bytes,
    input  logic              arm_req,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [EXT_W-1:0]  arm_ext,
    input  logic [HINT_W-1:0] arm_hint,
    output logic              arm_rsp_valid,
    output logic [1:0]        arm_rsp_code,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_mtype,
    input  logic              wait_req,
    output logic              wait_rsp_valid,
    output logic              wait_rsp_now,
    output logic              wake_pulse,
    output logic              watch_armed,
    output logic              watch_fired
);
    logic              arm_ok;
    arm_code_t         arm_code;
    arm_code_t         rsp_code;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ref_addr;
    logic              same_line;
    logic              st_hit;

    // Static outputs: feature status and readable line size.
    always_comb begin
        feature_present = !feature_off;
        line_bytes      = 16'(LINE_BYTES);
    end

    swu_arm_check #(.EXT_W(EXT_W)) u_check (
        .arm_req     (arm_req),
        .feature_off (feature_off),
        .arm_ext     (arm_ext),
        .arm_ok      (arm_ok),
        .arm_code    (arm_code)
    );

    // Reference line: the line being armed this cycle, otherwise the latched base.
    always_comb begin
        ref_addr = arm_ok ? arm_addr : base;
    end

    swu_line_match #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_match (
        .addr_a    (st_addr),
        .addr_b    (ref_addr),
        .same_line (same_line)
    );

    // Qualified store hit: valid write-back store in the armed (or arming) line.
    always_comb begin
        st_hit = st_valid && (st_mtype == MT_WRITE_BACK) && (watch_armed || arm_ok) && same_line;
    end

    swu_watch_state #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm_req        (arm_req),
        .arm_ok         (arm_ok),
        .arm_code       (arm_code),
        .arm_addr       (arm_addr),
        .st_hit         (st_hit),
        .wait_req       (wait_req),
        .base           (base),
        .armed          (watch_armed),
        .fired          (watch_fired),
        .arm_rsp_valid  (arm_rsp_valid),
        .arm_rsp_code   (rsp_code),
        .wait_rsp_valid (wait_rsp_valid),
        .wait_rsp_now   (wait_rsp_now),
        .wake_pulse     (wake_pulse)
    );

    // Drive the plain status port from the enum.
    always_comb begin
        arm_rsp_code = rsp_code;
    end
endmodule

// File: rtl/swu_chk.sv
// Property checker for store_watch_unit, attached by the bind at the end of this file.
// Assumes: observes top-level ports only.
module swu_chk #(
    parameter int EXT_W  = 32,
    parameter int HINT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              feature_off,
    input logic              feature_present,
    input logic              arm_req,
    input logic [EXT_W-1:0]  arm_ext,
    input logic [HINT_W-1:0] arm_hint,
    input logic              arm_rsp_valid,
    input logic [1:0]        arm_rsp_code,
    input logic              st_valid,
    input logic [1:0]        st_mtype,
    input logic              wait_req,
    input logic              wait_rsp_valid,
    input logic              wait_rsp_now,
    input logic              wake_pulse,
    input logic              watch_armed,
    input logic              watch_fired
);
    // R2
    arm_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_req && !feature_off && arm_ext == '0 && !wait_req)
        |=> (arm_rsp_valid && arm_rsp_code == 2'b00 && watch_armed));

    // R4
    non_wb_store_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_mtype != 2'b11 && !arm_req)
        |=> (watch_fired == $past(watch_fired)));

    // R5
    ext_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_req && !feature_off && arm_ext != '0 && !wait_req)
        |=> (arm_rsp_valid && arm_rsp_code == 2'b01 && watch_armed == $past(watch_armed)));

    // R6
    hint_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_req && !feature_off && arm_ext == '0 && arm_hint != '0)
        |=> (arm_rsp_code == 2'b00));

    // R7
    disabled_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feature_off |-> !feature_present);

    // R7
    disabled_arm_ill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_req && feature_off && !wait_req)
        |=> (arm_rsp_code == 2'b10 && watch_armed == $past(watch_armed)));

    // R10
    wait_unarmed_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && !watch_armed && !arm_req)
        |=> (wait_rsp_valid && wait_rsp_now && !watch_armed));

    // R11
    wake_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (!watch_armed && watch_fired));

    // R11
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
endmodule

bind store_watch_unit swu_chk #(.EXT_W(EXT_W), .HINT_W(HINT_W)) u_swu_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .feature_off     (feature_off),
    .feature_present (feature_present),
    .arm_req         (arm_req),
    .arm_ext         (arm_ext),
    .arm_hint        (arm_hint),
    .arm_rsp_valid   (arm_rsp_valid),
    .arm_rsp_code    (arm_rsp_code),
    .st_valid        (st_valid),
    .st_mtype        (st_mtype),
    .wait_req        (wait_req),
    .wait_rsp_valid  (wait_rsp_valid),
    .wait_rsp_now    (wait_rsp_now),
    .wake_pulse      (wake_pulse),
    .watch_armed     (watch_armed),
    .watch_fired     (watch_fired)
);

// File: tb/tb_store_watch_unit.sv
// Directed bench for store_watch_unit: one task per scenario, each checking its own results.
module tb_store_watch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feature_off = 1'b0;
    logic        feature_present;
    logic [15:0] line_bytes;
    logic        arm_req = 1'b0;
    logic [31:0] arm_addr = '0;
    logic [31:0] arm_ext = '0;
    logic [31:0] arm_hint = '0;
    logic        arm_rsp_valid;
    logic [1:0]  arm_rsp_code;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_mtype = '0;
    logic        wait_req = 1'b0;
    logic        wait_rsp_valid;
    logic        wait_rsp_now;
    logic        wake_pulse;
    logic        watch_armed;
    logic        watch_fired;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [1:0] WB = 2'b11;

    always #10 clk = ~clk;

    store_watch_unit dut (
        .clk(clk), .rst_n(rst_n), .feature_off(feature_off), .feature_present(feature_present),
        .line_bytes(line_bytes), .arm_req(arm_req), .arm_addr(arm_addr), .arm_ext(arm_ext),
        .arm_hint(arm_hint), .arm_rsp_valid(arm_rsp_valid), .arm_rsp_code(arm_rsp_code),
        .st_valid(st_valid), .st_addr(st_addr), .st_mtype(st_mtype), .wait_req(wait_req),
        .wait_rsp_valid(wait_rsp_valid), .wait_rsp_now(wait_rsp_now), .wake_pulse(wake_pulse),
        .watch_armed(watch_armed), .watch_fired(watch_fired)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus applied at a falling edge; outputs are settled when it returns.
    task automatic step(input logic a, input logic [31:0] aa, input logic [31:0] ae,
                        input logic [31:0] ah, input logic s, input logic [31:0] sa,
                        input logic [1:0] sm, input logic w);
        @(negedge clk);
        arm_req = a; arm_addr = aa; arm_ext = ae; arm_hint = ah;
        st_valid = s; st_addr = sa; st_mtype = sm; wait_req = w;
        @(negedge clk);
        arm_req = 1'b0; st_valid = 1'b0; wait_req = 1'b0;
        arm_ext = '0; arm_hint = '0;
    endtask

    task automatic arm(input logic [31:0] a);
        step(1'b1, a, 0, 0, 1'b0, 0, 2'b00, 1'b0);
    endtask

    task automatic store(input logic [31:0] a, input logic [1:0] mt);
        step(1'b0, 0, 0, 0, 1'b1, a, mt, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 1'b0, 0, 2'b00, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 armed", {31'b0, watch_armed}, 0);
        chk("R1 fired", {31'b0, watch_fired}, 0);
        chk("R1 rsp", {29'b0, arm_rsp_valid, wait_rsp_valid, wake_pulse}, 0);
        chk("R7 present", {31'b0, feature_present}, 1);
        chk("R8 line size", {16'b0, line_bytes}, 64);
        store(32'h0000_0000, WB);
        chk("R1 unarmed store at base 0", {31'b0, watch_fired}, 0);
    endtask

    task automatic t_arm_basic();
        arm(32'h1234_5678);
        chk("R2 rsp valid", {31'b0, arm_rsp_valid}, 1);
        chk("R2 code", {30'b0, arm_rsp_code}, 0);
        chk("R2 armed", {31'b0, watch_armed}, 1);
        chk("R2 fired clear", {31'b0, watch_fired}, 0);
        store(32'h1234_5640, WB);
        chk("R2 base masked, low end of line", {31'b0, watch_fired}, 1);
        arm(32'h1234_5678);
        store(32'h1234_567F, WB);
        chk("R3 high end of line", {31'b0, watch_fired}, 1);
    endtask

    task automatic t_line_edges();
        arm(32'h0000_1000);
        store(32'h0000_1040, WB);
        chk("R3 next line", {31'b0, watch_fired}, 0);
        store(32'h0000_0FFF, WB);
        chk("R3 previous line", {31'b0, watch_fired}, 0);
        store(32'h0000_1020, WB);
        chk("R3 middle of line", {31'b0, watch_fired}, 1);
    endtask

    task automatic t_mtype();
        arm(32'h0000_2000);
        for (int m = 0; m < 3; m++) begin
            store(32'h0000_2010, m[1:0]);
            chk($sformatf("R4 mtype %0d", m), {31'b0, watch_fired}, 0);
        end
        store(32'h0000_2010, WB);
        chk("R4 write-back fires", {31'b0, watch_fired}, 1);
    endtask

    task automatic t_ext_fault();
        arm(32'h0000_3000);
        step(1'b1, 32'h0000_5000, 32'h0000_0001, 0, 1'b0, 0, 2'b00, 1'b0);
        chk("R5 code bit0", {30'b0, arm_rsp_code}, 1);
        chk("R5 still armed", {31'b0, watch_armed}, 1);
        step(1'b1, 32'h0000_5000, 32'h8000_0000, 0, 1'b0, 0, 2'b00, 1'b0);
        chk("R5 code bit31", {30'b0, arm_rsp_code}, 1);
        store(32'h0000_5000, WB);
        chk("R5 base not moved", {31'b0, watch_fired}, 0);
        store(32'h0000_3000, WB);
        chk("R5 old base still watched", {31'b0, watch_fired}, 1);
        step(1'b1, 32'h0000_5000, 32'h0000_0004, 0, 1'b0, 0, 2'b00, 1'b0);
        chk("R5 fired kept", {31'b0, watch_fired}, 1);
    endtask

    task automatic t_hint();
        step(1'b1, 32'h0000_6000, 0, 32'hFFFF_FFFF, 1'b0, 0, 2'b00, 1'b0);
        chk("R6 code", {30'b0, arm_rsp_code}, 0);
        chk("R6 armed", {31'b0, watch_armed}, 1);
        chk("R6 fired clear", {31'b0, watch_fired}, 0);
        store(32'h0000_6004, WB);
        chk("R6 watch works", {31'b0, watch_fired}, 1);
    endtask

    task automatic t_disable();
        arm(32'h0000_8000);
        @(negedge clk);
        feature_off = 1'b1;
        #1;
        chk("R7 present low", {31'b0, feature_present}, 0);
        arm(32'h0000_7000);
        chk("R7 code", {30'b0, arm_rsp_code}, 2);
        chk("R7 still armed", {31'b0, watch_armed}, 1);
        store(32'h0000_7000, WB);
        chk("R7 base not moved", {31'b0, watch_fired}, 0);
        store(32'h0000_8000, WB);
        chk("R7 old base watched", {31'b0, watch_fired}, 1);
        @(negedge clk);
        feature_off = 1'b0;
        #1;
        chk("R7 present back", {31'b0, feature_present}, 1);
    endtask

    task automatic t_same_cycle();
        arm(32'h0000_9000);
        store(32'h0000_9000, WB);
        arm(32'h0000_A000);
        chk("R9 arm clears fired", {31'b0, watch_fired}, 0);
        step(1'b1, 32'h0000_B000, 0, 0, 1'b1, 32'h0000_B008, WB, 1'b0);
        chk("R9 store wins", {31'b0, watch_fired}, 1);
        step(1'b1, 32'h0000_C000, 0, 0, 1'b1, 32'h0000_B000, WB, 1'b0);
        chk("R9 old base not matched", {31'b0, watch_fired}, 0);
    endtask

    task automatic t_wait_now();
        arm(32'h0000_D000);
        store(32'h0000_D000, WB);
        step(1'b0, 0, 0, 0, 1'b0, 0, 2'b00, 1'b1);
        chk("R10 fired: rsp", {30'b0, wait_rsp_valid, wait_rsp_now}, 3);
        chk("R10 fired: disarm", {31'b0, watch_armed}, 0);
        step(1'b0, 0, 0, 0, 1'b0, 0, 2'b00, 1'b1);
        chk("R10 unarmed: rsp", {30'b0, wait_rsp_valid, wait_rsp_now}, 3);
        arm(32'h0000_E000);
        step(1'b0, 0, 0, 0, 1'b1, 32'h0000_E030, WB, 1'b1);
        chk("R10 same-cycle store: rsp", {30'b0, wait_rsp_valid, wait_rsp_now}, 3);
        chk("R10 same-cycle store: disarm", {31'b0, watch_armed}, 0);
        chk("R10 same-cycle store: no wake", {31'b0, wake_pulse}, 0);
    endtask

    task automatic t_wait_sleep();
        arm(32'h0000_F000);
        step(1'b0, 0, 0, 0, 1'b0, 0, 2'b00, 1'b1);
        chk("R11 sleep rsp", {30'b0, wait_rsp_valid, wait_rsp_now}, 2);
        chk("R11 still armed", {31'b0, watch_armed}, 1);
        store(32'h0000_F040, WB);
        chk("R11 miss no wake", {31'b0, wake_pulse}, 0);
        store(32'h0000_F000, 2'b01);
        chk("R11 non-wb no wake", {31'b0, wake_pulse}, 0);
        store(32'h0000_F03C, WB);
        chk("R11 wake", {29'b0, wake_pulse, watch_armed, watch_fired}, 3'b101);
        idle();
        chk("R11 single pulse", {31'b0, wake_pulse}, 0);
    endtask

    initial begin
        t_reset();
        t_arm_basic();
        t_line_edges();
        t_mtype();
        t_ext_fault();
        t_hint();
        t_disable();
        t_same_cycle();
        t_wait_now();
        t_wait_sleep();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: all requirements, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule